// File: doc/BRIEF.md
# FIFO Level Threshold Interrupt Unit

This block holds a transmit queue and a receive queue, each 64 entries deep. Each queue raises a level-sensitive interrupt when its fill level crosses a threshold that software sets. The transmit interrupt asks for more data: it is high while the transmit queue holds no more entries than its threshold. The receive interrupt asks for data to be drained: it is high once the receive queue holds more entries than its threshold. The two comparisons are therefore offset from each other by one entry.

Software reaches three registers through a single-cycle write port and a combinational read port:
- an enable register at offset 0x08, bit 0;
- the transmit threshold at offset 0x18;
- the receive threshold at offset 0x1C.

Threshold writes are dropped silently in two cases: when the value is out of range, or when the unit is enabled. Clearing the enable bit empties both queues.

The receive threshold register has one bit more than the transmit one. This lets it hold a value equal to the depth, which turns its interrupt off for good. Both queues accept push and pop strobes, and each shows its head entry and its fill level.

Top module: `fifo_thr_irq`

## Requirements
- R1: After reset, all three registers read 0, both levels are 0, `tx_irq` is 1 and `rx_irq` is 0.
- R2: `tx_irq` is 1 exactly when the transmit level is less than or equal to the transmit threshold. A threshold of 0 fires only on an empty queue.
- R3: `rx_irq` is 1 exactly when the receive level is greater than or equal to the receive threshold plus one. A threshold of 0 fires once one entry is present.
- R4: A write to offset 0x18 with a 32-bit value of 64 or more is dropped, and the register keeps its old value. Values 0 to 63 are stored in bits 5:0.
- R5: A write to offset 0x1C with a 32-bit value greater than 64 is dropped. Values 0 to 64 are stored in bits 6:0, and a stored 64 keeps `rx_irq` at 0 even with a full queue.
- R6: While the enable bit (offset 0x08, bit 0) is 1, writes to either threshold are dropped.
- R7: Reads return the register value zero-extended, so all bits above each field read 0. Offsets other than 0x08, 0x18 and 0x1C read 0, and writes to them change nothing.
- R8: Each queue returns entries in the order they were pushed. The read-data output shows the oldest entry.
- R9: A push to a full queue (level 64) is dropped. A pop from an empty queue is ignored. Levels stay within 0 to 64.
- R10: A push and a pop in the same cycle that are both accepted leave the level unchanged. At full, only the pop is accepted; at empty, only the push is.
- R11: Writing 0 to bit 0 of the enable register while it is 1 empties both queues at the next clock edge. Afterwards `tx_irq` is 1 and `rx_irq` is 0.
- R12: A flush takes priority over a push or pop in the same cycle. That push is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tx_push | input | 1 | Push strobe, transmit queue |
| tx_wdata | input | DW | Data pushed into the transmit queue |
| tx_pop | input | 1 | Pop strobe, transmit queue |
| tx_rdata | output | DW | Head of the transmit queue |
| tx_level | output | 7 | Transmit fill level |
| rx_push | input | 1 | Push strobe, receive queue |
| rx_wdata | input | DW | Data pushed into the receive queue |
| rx_pop | input | 1 | Pop strobe, receive queue |
| rx_rdata | output | DW | Head of the receive queue |
| rx_level | output | 7 | Receive fill level |
| tx_irq | output | 1 | Transmit-empty interrupt (level) |
| rx_irq | output | 1 | Receive-full interrupt (level) |

## Verification
Two pairs of events can fall in the same clock.

The first pair is a push and a pop on one queue. The bench drives both strobes together at an intermediate level, at level 64 and at level 0. It expects, in turn:
- an unchanged level;
- a drop of one, because the push is refused;
- a rise of one, because the pop is refused.

The second pair is a flush and a queue operation. The bench clears the enable bit in the same cycle as a transmit push. It judges the result by an empty transmit queue and by the interrupt levels one cycle later.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h08;
  localparam logic [REG_AW-1:0] OFS_TX_THR = 8'h18;
  localparam logic [REG_AW-1:0] OFS_RX_THR = 8'h1C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_TX_THR,
    SEL_RX_THR
  } reg_sel_e;

  // Decode a byte offset to a register selector.
  function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] ofs);
    case (ofs)
      OFS_ENABLE: return SEL_ENABLE;
      OFS_TX_THR: return SEL_TX_THR;
      OFS_RX_THR: return SEL_RX_THR;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Transmit threshold must address a slot strictly below the depth.
  function automatic logic tx_thr_legal(input logic [REG_DW-1:0] v, input int unsigned depth);
    return v < REG_DW'(depth);
  endfunction

  // Receive threshold may equal the depth (interrupt never fires).
  function automatic logic rx_thr_legal(input logic [REG_DW-1:0] v, input int unsigned depth);
    return v <= REG_DW'(depth);
  endfunction

  // Transmit-empty condition: level at or below threshold.
  function automatic logic tx_low(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  // Receive-full condition: level at least threshold plus one.
  function automatic logic rx_high(input int unsigned lvl, input int unsigned thr);
    return lvl >= thr + 1;
  endfunction

endpackage

// File: rtl/fthr_fifo.sv
module fthr_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, empty;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/fthr_regs.sv
module fthr_regs
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned RW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic              enable,
  output logic [TW-1:0]     tx_thr,
  output logic [RW-1:0]     rx_thr,
  output logic              flush,
  output logic              tx_thr_we,
  output logic              rx_thr_we
);

  reg_sel_e sel;
  logic     en_we;

  assign sel       = decode_ofs(addr);
  assign en_we     = wr && (sel == SEL_ENABLE);
  assign tx_thr_we = wr && (sel == SEL_TX_THR) && !enable && tx_thr_legal(wdata, DEPTH);
  assign rx_thr_we = wr && (sel == SEL_RX_THR) && !enable && rx_thr_legal(wdata, DEPTH);
  assign flush     = en_we && enable && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      tx_thr <= '0;
      rx_thr <= '0;
    end else begin
      if (en_we)     enable <= wdata[0];
      if (tx_thr_we) tx_thr <= wdata[TW-1:0];
      if (rx_thr_we) rx_thr <= wdata[RW-1:0];
    end
  end

  always_comb begin
    case (decode_ofs(addr))
      SEL_ENABLE: rdata = REG_DW'(enable);
      SEL_TX_THR: rdata = REG_DW'(tx_thr);
      SEL_RX_THR: rdata = REG_DW'(rx_thr);
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/fthr_irq.sv
module fthr_irq
  import fifo_thr_pkg::*;
#(
  parameter int unsigned CW = 7,
  parameter int unsigned TW = 6,
  parameter int unsigned RW = 7
) (
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic [TW-1:0] tx_thr,
  input  logic [RW-1:0] rx_thr,
  output logic          tx_irq,
  output logic          rx_irq
);

  assign tx_irq = tx_low(32'(tx_level), 32'(tx_thr));
  assign rx_irq = rx_high(32'(rx_level), 32'(rx_thr));

endmodule

// File: rtl/fifo_thr_irq.sv
module fifo_thr_irq
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned RW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              tx_push,
  input  logic [DW-1:0]     tx_wdata,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_rdata,
  output logic [CW-1:0]     tx_level,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_wdata,
  input  logic              rx_pop,
  output logic [DW-1:0]     rx_rdata,
  output logic [CW-1:0]     rx_level,
  output logic              tx_irq,
  output logic              rx_irq
);

  // Named internal events, observed by the bound checker.
  logic          enable_w, flush_w, tx_thr_we_w, rx_thr_we_w;
  logic [TW-1:0] tx_thr_w;
  logic [RW-1:0] rx_thr_w;
  logic          tx_push_ok_w, tx_pop_ok_w, rx_push_ok_w, rx_pop_ok_w;

  fthr_regs #(.DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .enable    (enable_w),
    .tx_thr    (tx_thr_w),
    .rx_thr    (rx_thr_w),
    .flush     (flush_w),
    .tx_thr_we (tx_thr_we_w),
    .rx_thr_we (rx_thr_we_w)
  );

  fthr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_w),
    .push    (tx_push),
    .wdata   (tx_wdata),
    .pop     (tx_pop),
    .rdata   (tx_rdata),
    .level   (tx_level),
    .push_ok (tx_push_ok_w),
    .pop_ok  (tx_pop_ok_w)
  );

  fthr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_w),
    .push    (rx_push),
    .wdata   (rx_wdata),
    .pop     (rx_pop),
    .rdata   (rx_rdata),
    .level   (rx_level),
    .push_ok (rx_push_ok_w),
    .pop_ok  (rx_pop_ok_w)
  );

  fthr_irq #(.CW(CW), .TW(TW), .RW(RW)) u_irq (
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_thr   (tx_thr_w),
    .rx_thr   (rx_thr_w),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
  );

endmodule

// File: rtl/fifo_thr_irq_chk.sv
module fifo_thr_irq_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7,
  parameter int unsigned TW    = 6,
  parameter int unsigned RW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          flush,
  input logic          tx_thr_we,
  input logic          rx_thr_we,
  input logic [TW-1:0] tx_thr,
  input logic [RW-1:0] rx_thr,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic          tx_push_ok,
  input logic          tx_pop_ok,
  input logic          rx_push_ok,
  input logic          rx_pop_ok
);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  a_r5_rx_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_thr <= RW'(DEPTH));

  a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(tx_thr) && $stable(rx_thr));

  a_r6_no_we_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> !tx_thr_we && !rx_thr_we);

  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_level == '0) && (rx_level == '0) && tx_irq && !rx_irq);

  a_r2_empty_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_irq);

  a_r3_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_irq);

  a_r10_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && tx_push_ok && tx_pop_ok) |=> $stable(tx_level));

  a_r10_rx_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rx_push_ok && rx_pop_ok) |=> $stable(rx_level));

  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (tx_level == CW'(DEPTH)) && !tx_pop_ok) |=> (tx_level == CW'(DEPTH)));

endmodule

bind fifo_thr_irq fifo_thr_irq_chk #(
  .DEPTH(DEPTH), .CW(CW), .TW(TW), .RW(RW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable_w),
  .flush      (flush_w),
  .tx_thr_we  (tx_thr_we_w),
  .rx_thr_we  (rx_thr_we_w),
  .tx_thr     (tx_thr_w),
  .rx_thr     (rx_thr_w),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .tx_push_ok (tx_push_ok_w),
  .tx_pop_ok  (tx_pop_ok_w),
  .rx_push_ok (rx_push_ok_w),
  .rx_pop_ok  (rx_pop_ok_w)
);

// File: tb/fifo_thr_irq_bench.sv
`timescale 1ns/1ps
module fifo_thr_irq_bench;

  localparam int DW    = 8;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [6:0]  tx_level, rx_level;
  logic        tx_irq, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fifo_thr_irq #(.DW(DW), .DEPTH(DEPTH)) u_fifo_thr_irq (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_level(tx_level),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Register write then read-back vectors, unit disabled.
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h18, 32'd5,          32'd5,  4'd4},  // R4 legal
    '{8'h18, 32'd63,         32'd63, 4'd4},  // R4 top legal
    '{8'h18, 32'd64,         32'd63, 4'd4},  // R4 equal depth dropped
    '{8'h18, 32'h100,        32'd63, 4'd4},  // R4 high bits dropped
    '{8'h1C, 32'd64,         32'd64, 4'd5},  // R5 equal depth kept
    '{8'h1C, 32'd65,         32'd64, 4'd5},  // R5 over depth dropped
    '{8'h1C, 32'd0,          32'd0,  4'd5},  // R5 zero
    '{8'h1C, 32'hFFFF_FFFF,  32'd0,  4'd5},  // R5 huge dropped
    '{8'h18, 32'd0,          32'd0,  4'd4},  // R4 back to zero
    '{8'h40, 32'd7,          32'd0,  4'd7},  // R7 unmapped
    '{8'h08, 32'd0,          32'd0,  4'd7}   // R7 enable stays off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  // Drive at negedge; the following negedge sees the result.
  task automatic step();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic qop(input bit tp, input bit tpp, input bit rp, input bit rpp,
                     input logic [DW-1:0] td, input logic [DW-1:0] rd);
    tx_push = tp; tx_pop = tpp; rx_push = rp; rx_pop = rpp;
    tx_wdata = td; rx_wdata = rd;
    step();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    int lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    reg_read(8'h08, rd); check("R1", rd, 0, "enable after reset");
    reg_read(8'h18, rd); check("R1", rd, 0, "tx thr after reset");
    reg_read(8'h1C, rd); check("R1", rd, 0, "rx thr after reset");
    check("R1", 32'(tx_level), 0, "tx level");
    check("R1", 32'(rx_level), 0, "rx level");
    check("R1", 32'(tx_irq), 1, "tx irq");
    check("R1", 32'(rx_irq), 0, "rx irq");

    // Register vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_write(VEC[i].addr, VEC[i].wdata);
      reg_read(VEC[i].addr, rd);
      check($sformatf("R%0d", VEC[i].req), rd, VEC[i].exp, $sformatf("vector %0d", i));
    end

    // R2 / R3 / R8 threshold sweeps
    @(negedge clk);
    reg_write(8'h18, 32'd3);
    reg_write(8'h1C, 32'd2);
    check("R2", 32'(tx_irq), 1, "tx irq at level 0 thr 3");
    for (int k = 1; k <= 5; k++) begin
      qop(1, 0, 1, 0, DW'(8'hA0 + k), DW'(8'h50 + k));
      check("R2", 32'(tx_irq), 32'(k <= 3), $sformatf("tx irq at level %0d", k));
      check("R3", 32'(rx_irq), 32'(k >= 3), $sformatf("rx irq at level %0d", k));
    end
    for (int k = 1; k <= 5; k++) begin
      check("R8", 32'(tx_rdata), 32'(8'hA0 + k), "tx head order");
      check("R8", 32'(rx_rdata), 32'(8'h50 + k), "rx head order");
      qop(0, 1, 0, 1, '0, '0);
    end
    check("R9", 32'(tx_level), 0, "tx drained");

    // R3 threshold zero fires on one entry
    reg_write(8'h1C, 32'd0);
    check("R3", 32'(rx_irq), 0, "rx irq empty thr 0");
    qop(0, 0, 1, 0, '0, 8'h11);
    check("R3", 32'(rx_irq), 1, "rx irq one entry thr 0");
    qop(0, 0, 0, 1, '0, '0);

    // R9 / R10 full and empty boundaries
    for (int k = 0; k < DEPTH; k++) qop(1, 0, 0, 0, DW'(k), '0);
    check("R9", 32'(tx_level), 64, "tx full");
    qop(1, 0, 0, 0, 8'hEE, '0);
    check("R9", 32'(tx_level), 64, "push to full dropped");
    check("R8", 32'(tx_rdata), 0, "head unchanged after drop");
    qop(1, 1, 0, 0, 8'hEE, '0);
    check("R10", 32'(tx_level), 63, "push+pop at full");
    qop(1, 1, 0, 0, 8'hEF, '0);
    check("R10", 32'(tx_level), 63, "push+pop mid level");
    lvl = 63;
    while (lvl > 0) begin qop(0, 1, 0, 0, '0, '0); lvl--; end
    check("R9", 32'(tx_level), 0, "drained");
    qop(0, 1, 0, 0, '0, '0);
    check("R9", 32'(tx_level), 0, "pop empty ignored");
    qop(1, 1, 0, 0, 8'h77, '0);
    check("R10", 32'(tx_level), 1, "push+pop at empty");
    check("R8", 32'(tx_rdata), 32'h77, "push at empty stored");
    qop(0, 1, 0, 0, '0, '0);

    // R5 receive threshold at depth never fires
    reg_write(8'h1C, 32'd64);
    for (int k = 0; k < DEPTH; k++) qop(0, 0, 1, 0, '0, DW'(k));
    check("R5", 32'(rx_level), 64, "rx full");
    check("R5", 32'(rx_irq), 0, "rx irq off at thr 64");

    // R6 / R7 enable lock
    reg_write(8'h08, 32'hFFFF_FFFF);
    reg_read(8'h08, rd); check("R7", rd, 1, "enable reserved bits zero");
    reg_write(8'h18, 32'd10);
    reg_read(8'h18, rd); check("R6", rd, 3, "tx thr locked");
    reg_write(8'h1C, 32'd5);
    reg_read(8'h1C, rd); check("R6", rd, 64, "rx thr locked");

    // R11 / R12 flush with a same-cycle push
    qop(1, 0, 0, 0, 8'h01, '0);
    qop(1, 0, 0, 0, 8'h02, '0);
    check("R2", 32'(tx_irq), 1, "tx irq level 2 thr 3");
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'd0;
    tx_push = 1'b1; tx_wdata = 8'h99;
    step();
    check("R12", 32'(tx_level), 0, "flush beats push");
    check("R11", 32'(rx_level), 0, "rx flushed");
    check("R11", 32'(tx_irq), 1, "tx irq after flush");
    check("R11", 32'(rx_irq), 0, "rx irq after flush");
    reg_read(8'h08, rd); check("R11", rd, 0, "enable cleared");
    reg_write(8'h18, 32'd7);
    reg_read(8'h18, rd); check("R6", rd, 7, "tx thr writable again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule